// File: doc/BRIEF.md
# Record-to-Tile Layout Transformer

This block sits on the data path between a host link and device memory. It rearranges records so that a wide parallel engine can read them efficiently. In the forward direction it takes a stream of records, each made of several fields and packed one after another. It emits tiles. Each tile holds the same field from a group of consecutive records, laid side by side. One such group of records is a chunk. Each chunk leaves as one tile per field, in field order. In the reverse direction it accepts tiles and rebuilds the packed record stream.

The rearrangement is done on the fly, with no addressed memory copy. A gather register first collects a whole chunk from the input beats. It then passes the chunk to a holding shifter. On every cycle, a field-indexed selector moves a few bits of the current field from every record of that chunk into a tile assembler. The holding shifter and the tile assembler shift by the same amount in that cycle. Each finished tile drops into an output register. The number of bits moved per record per cycle is the beat width divided by the records per chunk. This keeps the shift stage as fast as the gather stage.

The reverse direction uses the same registers in the opposite order. A tile is captured and scattered back into the holding shifter under the same field index. The gather register then emits the rebuilt chunk as beats. All stage boundaries use valid/ready handshakes. The direction input may change only while the pipeline is empty.

Top module: `aos_tile_xform`

## Requirements
- R1: In forward mode, tile j of a chunk carries field j of record w at tile bits [w*FB +: FB], where FB = FIELD_BYTES*8 and w runs from 0 to TILE_OBJS-1.
- R2: In forward mode, input beat i of a chunk carries chunk bits [i*BEAT_BITS +: BEAT_BITS]. Field k of record w sits at chunk bit (w*NUM_FIELDS+k)*FB.
- R3: No tile of a chunk appears until every beat of that chunk has been accepted. While the gather register holds a complete chunk that the shifter cannot yet take, s_ready stays low and no beat is consumed.
- R4: The NUM_FIELDS tiles of a chunk leave in ascending field order, and chunks leave in arrival order.
- R5: A beat accepted with s_last high closes the chunk early. Every chunk bit above the accepted beats is zero in the emitted tiles.
- R6: In reverse mode, NUM_FIELDS tiles accepted on t_in_* in field order, using the tile format of R1, leave on m_* as chunk beats in the order and format of R2.
- R7: An output held valid with its ready low keeps its valid high and its data unchanged on the next cycle.
- R8: With every handshake always ready, consecutive tiles of one chunk leave exactly FB*TILE_OBJS/BEAT_BITS cycles apart.
- R9: After reset, t_out_valid and m_valid are low, and s_ready is high in forward mode.
- R10: Forward mode (dir = 0) never raises m_valid or t_in_ready. Reverse mode (dir = 1) never raises s_ready or t_out_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dir | input | 1 | 0 = records to tiles, 1 = tiles to records |
| s_valid | input | 1 | Record beat valid (forward) |
| s_ready | output | 1 | Record beat accepted (forward) |
| s_data | input | BEAT_BITS | Record beat payload |
| s_last | input | 1 | Closes the current chunk, with zero padding |
| t_out_valid | output | 1 | Tile valid (forward) |
| t_out_ready | input | 1 | Tile consumer ready |
| t_out_data | output | TILE_OBJS*FB | Tile payload |
| t_in_valid | input | 1 | Tile valid (reverse) |
| t_in_ready | output | 1 | Tile accepted (reverse) |
| t_in_data | input | TILE_OBJS*FB | Tile payload (reverse) |
| m_valid | output | 1 | Record beat valid (reverse) |
| m_ready | input | 1 | Record beat consumer ready |
| m_data | output | BEAT_BITS | Record beat payload (reverse) |

## Verification
A wrong field index or a slip in the shift count corrupts a whole tile. It lands bytes from the wrong field or record in the wrong lane. The error shows in the very first tile of the affected chunk, FB*TILE_OBJS/BEAT_BITS cycles after the shifter loads. A lost or extra beat count in the gather register shows up differently. The following tiles shift by whole beats, zero-padding leaks into full chunks, or s_ready stays low forever and the run hangs. Stall bugs show up as tile or beat payloads that change under a held valid. They also show up as a tile spacing other than the balanced rate.

// File: rtl/aos_tile_pkg.sv
package aos_tile_pkg;

    typedef enum logic {
        DIR_FWD = 1'b0,
        DIR_REV = 1'b1
    } xf_dir_e;

    // Holding shifter occupancy
    typedef enum logic [1:0] {
        XP_IDLE,   // empty, may load a chunk or the first reverse tile
        XP_DRAIN,  // forward: emitting tiles out of a loaded chunk
        XP_FILL,   // reverse: scattering tiles into the chunk
        XP_FULL    // reverse: rebuilt chunk waiting for the gather register
    } xp_state_e;

    // Bits taken from each record lane per cycle, balancing shift against gather
    function automatic int lane_bits(input int beat_bits, input int objs);
        return beat_bits / objs;
    endfunction

    function automatic int steps_per_tile(input int field_bits, input int lb);
        return field_bits / lb;
    endfunction

endpackage

// File: rtl/aos_chunk_buf.sv
// Gather register: collects beats into a chunk (forward) or emits a chunk as beats (reverse).
module aos_chunk_buf #(
    parameter int K  = 3,
    parameter int W  = 4,
    parameter int FB = 8,
    parameter int BW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rev,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [BW-1:0]     s_data,
    input  logic              s_last,
    output logic              a_valid,
    input  logic              a_ready,
    output logic [K*W*FB-1:0] a_chunk,
    input  logic              r_valid,
    output logic              r_ready,
    input  logic [K*W*FB-1:0] r_chunk,
    output logic              m_valid,
    input  logic              m_ready,
    output logic [BW-1:0]     m_data
);
    localparam int CH    = K * W * FB;
    localparam int BEATS = CH / BW;
    localparam int CW    = (BEATS > 1) ? $clog2(BEATS) : 1;

    logic [CH-1:0] chunk_q, merged;
    logic          full_q;
    logic [CW-1:0] cnt_q;
    logic          last_beat;

    assign last_beat = (cnt_q == CW'(BEATS - 1));

    // The first beat of a chunk clears the rest, so an early close leaves zeros
    always_comb begin
        merged = (cnt_q == '0) ? '0 : chunk_q;
        merged[int'(cnt_q)*BW +: BW] = s_data;
    end

    assign s_ready = !rev && !full_q;
    assign a_valid = !rev && full_q;
    assign a_chunk = chunk_q;
    assign r_ready = rev && !full_q;
    assign m_valid = rev && full_q;
    assign m_data  = chunk_q[int'(cnt_q)*BW +: BW];

    always_ff @(posedge clk) begin
        if (rst) begin
            chunk_q <= '0;
            full_q  <= 1'b0;
            cnt_q   <= '0;
        end else begin
            if (s_valid && s_ready) begin
                chunk_q <= merged;
                if (s_last || last_beat) begin
                    full_q <= 1'b1;
                    cnt_q  <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
            if (a_valid && a_ready) full_q <= 1'b0;
            if (r_valid && r_ready) begin
                chunk_q <= r_chunk;
                full_q  <= 1'b1;
                cnt_q   <= '0;
            end
            if (m_valid && m_ready) begin
                if (last_beat) begin
                    full_q <= 1'b0;
                    cnt_q  <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/aos_xpose_core.sv
// Holding shifter plus tile assembler, linked by a field-indexed select/scatter.
module aos_xpose_core
    import aos_tile_pkg::*;
#(
    parameter int K  = 3,
    parameter int W  = 4,
    parameter int FB = 8,
    parameter int L  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rev,
    input  logic              a_valid,
    output logic              a_ready,
    input  logic [K*W*FB-1:0] a_chunk,
    output logic              r_valid,
    input  logic              r_ready,
    output logic [K*W*FB-1:0] r_chunk,
    output logic              tf_valid,
    input  logic              tf_ready,
    output logic [W*FB-1:0]   tf_data,
    input  logic              tr_valid,
    output logic              tr_ready,
    input  logic [W*FB-1:0]   tr_data
);
    localparam int STEPS = steps_per_tile(FB, L);
    localparam int SW    = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam int KW    = (K > 1) ? $clog2(K) : 1;

    xp_state_e                     st_q;
    logic [W-1:0][K-1:0][FB-1:0]   b_q, b_nx;
    logic [W-1:0][FB-1:0]          c_q, c_nx;
    logic                          c_full;
    logic [KW-1:0]                 k_q;
    logic [SW-1:0]                 s_q;
    logic [L-1:0]                  ins_b, ins_c;
    logic                          take_f, step, step_last, k_last, load_a, load_t;

    // One step: field k_q of every record and every assembler lane shift down by L.
    // Forward feeds record bits into the lanes; reverse feeds lane bits into the records.
    always_comb begin
        b_nx  = b_q;
        c_nx  = c_q;
        ins_b = '0;
        ins_c = '0;
        for (int w = 0; w < W; w++) begin
            ins_b = rev ? c_q[w][L-1:0] : '0;
            ins_c = rev ? '0 : b_q[w][k_q][L-1:0];
            b_nx[w][k_q] = (b_q[w][k_q] >> L) | (FB'(ins_b) << (FB - L));
            c_nx[w]      = (c_q[w] >> L)      | (FB'(ins_c) << (FB - L));
        end
    end

    assign take_f    = !rev && c_full && tf_ready;
    assign step      = (st_q == XP_DRAIN && (!c_full || take_f)) ||
                       (st_q == XP_FILL && c_full);
    assign step_last = (s_q == SW'(STEPS - 1));
    assign k_last    = (k_q == KW'(K - 1));
    assign a_ready   = !rev && st_q == XP_IDLE;
    assign load_a    = a_valid && a_ready;
    assign tr_ready  = rev && !c_full && (st_q == XP_IDLE || st_q == XP_FILL);
    assign load_t    = tr_valid && tr_ready;
    assign tf_valid  = !rev && c_full;
    assign tf_data   = c_q;
    assign r_valid   = (st_q == XP_FULL);
    assign r_chunk   = b_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= XP_IDLE;
            b_q    <= '0;
            c_q    <= '0;
            c_full <= 1'b0;
            k_q    <= '0;
            s_q    <= '0;
        end else begin
            if (take_f) c_full <= 1'b0;
            if (load_a) begin
                b_q  <= a_chunk;
                st_q <= XP_DRAIN;
                k_q  <= '0;
                s_q  <= '0;
            end
            if (load_t) begin
                c_q    <= tr_data;
                c_full <= 1'b1;
                if (st_q == XP_IDLE) begin
                    st_q <= XP_FILL;
                    k_q  <= '0;
                    s_q  <= '0;
                end
            end
            if (step) begin
                b_q <= b_nx;
                c_q <= c_nx;
                s_q <= step_last ? '0 : s_q + 1'b1;
                if (step_last) begin
                    k_q    <= k_last ? '0 : k_q + 1'b1;
                    c_full <= !rev;
                    if (k_last) st_q <= rev ? XP_FULL : XP_IDLE;
                end
            end
            if (st_q == XP_FULL && r_ready) st_q <= XP_IDLE;
        end
    end
endmodule

// File: rtl/aos_tile_reg.sv
// Output register: drives tiles toward memory, or captures tiles from it.
module aos_tile_reg #(
    parameter int TB = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [TB-1:0] in_data,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [TB-1:0] out_data
);
    logic          v_q;
    logic [TB-1:0] d_q;

    assign in_ready  = !v_q || out_ready;
    assign out_valid = v_q;
    assign out_data  = d_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            v_q <= 1'b0;
            d_q <= '0;
        end else if (in_ready) begin
            v_q <= in_valid;
            if (in_valid) d_q <= in_data;
        end
    end
endmodule

// File: rtl/aos_tile_xform.sv
module aos_tile_xform
    import aos_tile_pkg::*;
#(
    parameter int NUM_FIELDS  = 3,
    parameter int TILE_OBJS   = 4,
    parameter int FIELD_BYTES = 1,
    parameter int BEAT_BITS   = 16
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            dir,
    input  logic                            s_valid,
    output logic                            s_ready,
    input  logic [BEAT_BITS-1:0]            s_data,
    input  logic                            s_last,
    output logic                            t_out_valid,
    input  logic                            t_out_ready,
    output logic [TILE_OBJS*FIELD_BYTES*8-1:0] t_out_data,
    input  logic                            t_in_valid,
    output logic                            t_in_ready,
    input  logic [TILE_OBJS*FIELD_BYTES*8-1:0] t_in_data,
    output logic                            m_valid,
    input  logic                            m_ready,
    output logic [BEAT_BITS-1:0]            m_data
);
    localparam int FB         = FIELD_BYTES * 8;
    localparam int LB         = lane_bits(BEAT_BITS, TILE_OBJS);
    localparam int TILE_BITS  = TILE_OBJS * FB;
    localparam int CHUNK_BITS = NUM_FIELDS * TILE_BITS;

    logic                  rev;
    logic                  a_valid, a_ready, r_valid, r_ready;
    logic [CHUNK_BITS-1:0] a_chunk, r_chunk;
    logic                  tf_valid, tf_ready, tr_valid, tr_ready;
    logic [TILE_BITS-1:0]  tf_data;
    logic                  d_in_valid, d_in_ready, d_out_valid, d_out_ready;
    logic [TILE_BITS-1:0]  d_in_data, d_out_data;

    assign rev = (xf_dir_e'(dir) == DIR_REV);

    aos_chunk_buf #(.K(NUM_FIELDS), .W(TILE_OBJS), .FB(FB), .BW(BEAT_BITS)) u_gather (
        .clk(clk), .rst(rst), .rev(rev),
        .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_last(s_last),
        .a_valid(a_valid), .a_ready(a_ready), .a_chunk(a_chunk),
        .r_valid(r_valid), .r_ready(r_ready), .r_chunk(r_chunk),
        .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data)
    );

    aos_xpose_core #(.K(NUM_FIELDS), .W(TILE_OBJS), .FB(FB), .L(LB)) u_core (
        .clk(clk), .rst(rst), .rev(rev),
        .a_valid(a_valid), .a_ready(a_ready), .a_chunk(a_chunk),
        .r_valid(r_valid), .r_ready(r_ready), .r_chunk(r_chunk),
        .tf_valid(tf_valid), .tf_ready(tf_ready), .tf_data(tf_data),
        .tr_valid(tr_valid), .tr_ready(tr_ready), .tr_data(d_out_data)
    );

    // The tile register faces memory in both directions; only its neighbours swap
    assign d_in_valid  = rev ? t_in_valid : tf_valid;
    assign d_in_data   = rev ? t_in_data  : tf_data;
    assign d_out_ready = rev ? tr_ready   : t_out_ready;

    aos_tile_reg #(.TB(TILE_BITS)) u_tile (
        .clk(clk), .rst(rst),
        .in_valid(d_in_valid), .in_ready(d_in_ready), .in_data(d_in_data),
        .out_valid(d_out_valid), .out_ready(d_out_ready), .out_data(d_out_data)
    );

    assign t_in_ready  = rev && d_in_ready;
    assign tf_ready    = !rev && d_in_ready;
    assign t_out_valid = !rev && d_out_valid;
    assign t_out_data  = d_out_data;
    assign tr_valid    = rev && d_out_valid;
endmodule

// File: rtl/aos_tile_xform_chk.sv
module aos_tile_xform_chk #(
    parameter int TB = 32,
    parameter int BW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          dir,
    input logic          s_ready,
    input logic          t_out_valid,
    input logic          t_out_ready,
    input logic [TB-1:0] t_out_data,
    input logic          t_in_ready,
    input logic          m_valid,
    input logic          m_ready,
    input logic [BW-1:0] m_data
);
    assert_tile_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (t_out_valid && !t_out_ready) |=> (t_out_valid && $stable(t_out_data)));

    assert_beat_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

    assert_fwd_quiet_reverse_R10: assert property (@(posedge clk) disable iff (rst)
        !dir |-> (!m_valid && !t_in_ready));

    assert_rev_quiet_forward_R10: assert property (@(posedge clk) disable iff (rst)
        dir |-> (!s_ready && !t_out_valid));

    assert_idle_after_reset_R9: assert property (@(posedge clk)
        $fell(rst) |-> (!t_out_valid && !m_valid));
endmodule

bind aos_tile_xform aos_tile_xform_chk #(.TB(TILE_BITS), .BW(BEAT_BITS)) u_chk (
    .clk(clk), .rst(rst), .dir(dir), .s_ready(s_ready),
    .t_out_valid(t_out_valid), .t_out_ready(t_out_ready), .t_out_data(t_out_data),
    .t_in_ready(t_in_ready), .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data)
);

// File: tb/sim_aos_tile_xform.sv
`timescale 1ns/1ps
module sim_aos_tile_xform;
    localparam int K     = 3;
    localparam int W     = 4;
    localparam int FB    = 8;
    localparam int BW    = 16;
    localparam int TB    = W * FB;
    localparam int CH    = K * TB;
    localparam int BEATS = CH / BW;
    localparam int STEPS = FB * W / BW;

    logic clk = 1'b0, rst = 1'b1, dir = 1'b0;
    logic s_valid = 1'b0, s_last = 1'b0, t_out_ready = 1'b0, t_in_valid = 1'b0, m_ready = 1'b0;
    logic [BW-1:0] s_data = '0;
    logic [TB-1:0] t_in_data = '0;
    logic s_ready, t_out_valid, t_in_ready, m_valid;
    logic [TB-1:0] t_out_data;
    logic [BW-1:0] m_data;

    int checks = 0, failures = 0, cyc = 0;
    bit gap_en = 1'b1, rdy_all = 1'b0;
    int tstamp [K];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    aos_tile_xform #(.NUM_FIELDS(K), .TILE_OBJS(W), .FIELD_BYTES(1), .BEAT_BITS(BW)) u0 (
        .clk(clk), .rst(rst), .dir(dir),
        .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_last(s_last),
        .t_out_valid(t_out_valid), .t_out_ready(t_out_ready), .t_out_data(t_out_data),
        .t_in_valid(t_in_valid), .t_in_ready(t_in_ready), .t_in_data(t_in_data),
        .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data)
    );

    task automatic chk(input bit ok, input string req, input logic [CH-1:0] act, input logic [CH-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Tile j expected per R1 from a chunk laid out per R2
    function automatic logic [TB-1:0] tile_of(input logic [CH-1:0] ch, input int j);
        logic [TB-1:0] t;
        for (int w = 0; w < W; w++) t[w*FB +: FB] = ch[(w*K + j)*FB +: FB];
        return t;
    endfunction

    function automatic logic [CH-1:0] rand_chunk();
        logic [CH-1:0] c;
        for (int i = 0; i < CH; i += 32) c[i +: 32] = $urandom;
        return c;
    endfunction

    task automatic send_fwd(input logic [CH-1:0] ch, input int first, input int n, input bit with_last);
        int i = first;
        while (i < first + n) begin
            @(negedge clk);
            if (gap_en && ($urandom % 4 == 0)) s_valid = 1'b0;
            else begin
                s_valid = 1'b1;
                s_data  = ch[i*BW +: BW];
                s_last  = with_last && (i == first + n - 1);
            end
            #1;
            if (s_valid && s_ready) i++;
        end
        @(negedge clk);
        s_valid = 1'b0;
        s_last  = 1'b0;
    endtask

    task automatic recv_tiles(input logic [CH-1:0] ch, input string req);
        int j = 0;
        while (j < K) begin
            @(negedge clk);
            t_out_ready = rdy_all ? 1'b1 : ($urandom % 3 != 0);
            #1;
            if (t_out_valid && t_out_ready) begin
                tstamp[j] = cyc;
                chk(t_out_data == tile_of(ch, j), req, CH'(t_out_data), CH'(tile_of(ch, j)));
                j++;
            end
        end
        @(negedge clk);
        t_out_ready = 1'b0;
    endtask

    task automatic send_tiles(input logic [CH-1:0] ch);
        int j = 0;
        while (j < K) begin
            @(negedge clk);
            if ($urandom % 4 == 0) t_in_valid = 1'b0;
            else begin
                t_in_valid = 1'b1;
                t_in_data  = tile_of(ch, j);
            end
            #1;
            if (t_in_valid && t_in_ready) j++;
        end
        @(negedge clk);
        t_in_valid = 1'b0;
    endtask

    task automatic recv_beats(input logic [CH-1:0] ch);
        int i = 0;
        while (i < BEATS) begin
            @(negedge clk);
            m_ready = ($urandom % 3 != 0);
            #1;
            if (m_valid && m_ready) begin
                chk(m_data == ch[i*BW +: BW], "R6 reverse beat", CH'(m_data), CH'(ch[i*BW +: BW]));
                i++;
            end
        end
        @(negedge clk);
        m_ready = 1'b0;
    endtask

    task automatic fwd_chunk(input logic [CH-1:0] ch);
        fork
            send_fwd(ch, 0, BEATS, 1'b0);
            recv_tiles(ch, "R1 R2 R4 tile");
        join
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog act=hung exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [CH-1:0] c1, c2, cp;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(!t_out_valid, "R9 tile valid after reset", CH'(t_out_valid), '0);
        chk(!m_valid, "R9 beat valid after reset", CH'(m_valid), '0);
        chk(s_ready, "R9 s_ready after reset", CH'(s_ready), CH'(1));
        chk(!t_in_ready, "R10 t_in_ready in forward", CH'(t_in_ready), '0);

        // Directed: each field byte encodes its record and field
        for (int w = 0; w < W; w++)
            for (int k = 0; k < K; k++) c1[(w*K + k)*FB +: FB] = 8'(w * 16 + k);
        fwd_chunk(c1);

        // Random back-to-back chunks with random stalls
        for (int n = 0; n < 6; n++) begin
            c1 = rand_chunk();
            c2 = rand_chunk();
            fork
                begin send_fwd(c1, 0, BEATS, 1'b0); send_fwd(c2, 0, BEATS, 1'b0); end
                begin recv_tiles(c1, "R4 chunk order a"); recv_tiles(c2, "R4 chunk order b"); end
            join
        end

        // R8: full-rate tile spacing
        gap_en = 1'b0; rdy_all = 1'b1;
        c1 = rand_chunk();
        fork
            send_fwd(c1, 0, BEATS, 1'b0);
            recv_tiles(c1, "R8 tile data");
        join
        for (int j = 1; j < K; j++)
            chk(tstamp[j] - tstamp[j-1] == STEPS, "R8 tile spacing",
                CH'(tstamp[j] - tstamp[j-1]), CH'(STEPS));
        gap_en = 1'b1; rdy_all = 1'b0;

        // R3: no tile before the chunk is complete
        c1 = rand_chunk();
        send_fwd(c1, 0, BEATS/2, 1'b0);
        repeat (10) @(negedge clk);
        chk(!t_out_valid, "R3 partial chunk held", CH'(t_out_valid), '0);
        fork
            send_fwd(c1, BEATS/2, BEATS - BEATS/2, 1'b0);
            recv_tiles(c1, "R3 partial then complete");
        join

        // R3: back-pressure while gather is full and the shifter is busy
        c1 = rand_chunk();
        c2 = rand_chunk();
        send_fwd(c1, 0, BEATS, 1'b0);
        send_fwd(c2, 0, BEATS, 1'b0);
        @(negedge clk);
        s_valid = 1'b1;
        s_data  = '1;
        repeat (8) @(negedge clk);
        chk(!s_ready, "R3 input back-pressured", CH'(s_ready), '0);
        chk(t_out_valid, "R3 tile waiting", CH'(t_out_valid), CH'(1));
        s_valid = 1'b0;
        recv_tiles(c1, "R3 first chunk intact");
        recv_tiles(c2, "R3 second chunk intact");

        // R5: early close pads with zeros
        for (int nb = 1; nb <= 2; nb++) begin
            c1 = rand_chunk();
            cp = c1 & ((CH'(1) << (nb * BW)) - 1);
            fork
                send_fwd(c1, 0, nb, 1'b1);
                recv_tiles(cp, "R5 padded chunk");
            join
        end

        // Reverse mode
        @(negedge clk);
        dir = 1'b1;
        #1;
        chk(!s_ready, "R10 s_ready in reverse", CH'(s_ready), '0);
        chk(!t_out_valid, "R10 t_out_valid in reverse", CH'(t_out_valid), '0);
        for (int n = 0; n < 5; n++) begin
            c1 = rand_chunk();
            fork
                send_tiles(c1);
                recv_beats(c1);
            join
        end

        // Back to forward after a drained reverse pass
        @(negedge clk);
        dir = 1'b0;
        c1 = rand_chunk();
        fwd_chunk(c1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule